// File: doc/BRIEF.md
# Bus-mapped GPIO port with word parity

A general-purpose I/O peripheral behind an AHB-Lite slave port. Two registers are visible to the bus. The output data register holds the value driven onto sixteen output pins. The direction register marks each pin as a driven output (bit set) or as an input (bit clear). An output pin whose direction bit is clear drives zero.

Both pin buses are seventeen bits wide. The top bit carries a parity bit for the sixteen data bits below it. Going out, that bit is generated from the driven data. Coming in, the whole seventeen-bit word is checked, and a registered error flag rises on a mismatch. A run-time select input picks odd or even parity for both directions. A test input forces the error flag.

Bus transfers use the usual split into an address phase and a data phase. The decoded offset and the direction of the transfer are registered in the address phase. Write data is consumed in the following cycle, and read data is returned in that same following cycle. The slave never inserts wait states.

Top module: `gpio_par_top`

## Requirements
- R1: A transfer counts only when `hsel_i`, `hready_i` and `htrans_i[1]` are all high in its address phase. Any other address phase leaves both registers unchanged and returns zero read data in the next cycle.
- R2: A write at offset 0x00 (decoded from `haddr_i[7:0]`) loads `hwdata_i[15:0]` from its data phase into the output data register. From the cycle after the data phase, the new value drives every pin whose direction bit is 1.
- R3: A write at offset 0x04 loads `hwdata_i[15:0]` from its data phase into the direction register. The new value takes effect from the cycle after the data phase.
- R4: `pin_out_o[i]` is 0 for every i in 0..15 whose direction bit is 0.
- R5: `pin_out_o[16]` makes the number of ones in `pin_out_o[16:0]` odd when `par_odd_i` is 1 and even when it is 0. It follows `par_odd_i` in the same cycle.
- R6: A read at offset 0x00 returns, in its data phase, a value on `hrdata_o[15:0]`. Each bit whose direction bit is 0 holds `pin_in_i` as sampled at the clock edge that ends the address phase. Each bit whose direction bit is 1 holds the output data register. `hrdata_o[31:16]` is 0.
- R7: A read at offset 0x04 returns the direction register on `hrdata_o[15:0]` in its data phase, with the upper bits at 0.
- R8: `hrdata_o` is all zero in every cycle that is not the data phase of a read at 0x00 or 0x04. A write to any other offset changes no register.
- R9: `hreadyout_o` is 1 in every cycle after reset.
- R10: `par_err_o` is 1 in the cycle after a clock edge at which `pin_in_i[16:0]` held an even count of ones with `par_odd_i`=1, or an odd count with `par_odd_i`=0. It is 0 after an edge with correct parity and with `fault_inj_i` low.
- R11: `par_err_o` is 1 in the cycle after any clock edge at which `fault_inj_i` was 1, whatever the parity of the input word.
- R12: While `rst_ni` is low, both registers and the error flag are cleared. During reset `pin_out_o[15:0]` is 0 and `pin_out_o[16]` equals `par_odd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| haddr_i | input | 32 | Bus address; bits [7:0] are decoded |
| htrans_i | input | 2 | Transfer type; bit 1 marks an active transfer |
| hwrite_i | input | 1 | 1 = write, 0 = read |
| hsel_i | input | 1 | Slave select |
| hready_i | input | 1 | Bus ready; the address phase is taken only when high |
| hwdata_i | input | 32 | Write data, sampled in the data phase |
| pin_in_i | input | 17 | Input pins; bit 16 is parity over bits 15:0 |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| fault_inj_i | input | 1 | Forces the parity error flag on the next cycle |
| hreadyout_o | output | 1 | Transfer done; tied high |
| hrdata_o | output | 32 | Read data, valid in a read data phase |
| pin_out_o | output | 17 | Output pins; bit 16 is generated parity |
| par_err_o | output | 1 | Registered parity error on incoming words |

## Verification
Two functions can meet in one cycle. The data phase of a write is also the address phase of the next transfer, so a write at 0x00 followed at once by a read at 0x00 makes the read see a register that changed on the edge between them. The bench provokes this with back-to-back write/read pairs and with long stretches of random traffic. It judges every cycle against a behavioural model that applies writes at the edge ending the data phase. In the same cycles the bench flips `par_odd_i` while the input parity is also changing. This checks that the generated output bit follows the new sense at once and that the error flag reflects the sense that held at the sampling edge.

// File: rtl/gpio_par_pkg.sv
`timescale 1ns/1ps
package gpio_par_pkg;
  localparam int unsigned DEC_W = 8;
  localparam logic [DEC_W-1:0] OFS_DATA = 8'h00;
  localparam logic [DEC_W-1:0] OFS_DIR  = 8'h04;

  typedef struct packed {
    logic             vld;
    logic             wr;
    logic [DEC_W-1:0] ofs;
  } aphase_t;

  // parity bit that completes a word whose reduction-xor is red
  function automatic logic par_fill(input logic red, input logic odd);
    return red ^ odd;
  endfunction
endpackage

// File: rtl/gpio_par_front.sv
`timescale 1ns/1ps
module gpio_par_front
  import gpio_par_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsel_i,
  input  logic             hready_i,
  input  logic [1:0]       htrans_i,
  input  logic             hwrite_i,
  input  logic [DEC_W-1:0] haddr_i,
  output logic             wr_data_o,
  output logic             wr_dir_o,
  output logic             rd_data_o,
  output logic             rd_dir_o
);
  aphase_t ap_d, ap_q;
  logic    unused_trans;

  assign unused_trans = htrans_i[0];

  always_comb begin
    ap_d.vld = hsel_i & hready_i & htrans_i[1];
    ap_d.wr  = hwrite_i;
    ap_d.ofs = haddr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ap_q <= '0;
    else         ap_q <= ap_d;
  end

  // data-phase strobes
  always_comb begin
    wr_data_o = ap_q.vld &  ap_q.wr & (ap_q.ofs == OFS_DATA);
    wr_dir_o  = ap_q.vld &  ap_q.wr & (ap_q.ofs == OFS_DIR);
    rd_data_o = ap_q.vld & ~ap_q.wr & (ap_q.ofs == OFS_DATA);
    rd_dir_o  = ap_q.vld & ~ap_q.wr & (ap_q.ofs == OFS_DIR);
  end
endmodule

// File: rtl/gpio_par_outregs.sv
`timescale 1ns/1ps
module gpio_par_outregs
  import gpio_par_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_data_i,
  input  logic          wr_dir_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          par_odd_i,
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] dir_o,
  output logic [DW:0]   pin_o
);
  logic [DW-1:0] data_q, dir_q, drv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_data_i) data_q <= wdata_i;
      if (wr_dir_i)  dir_q  <= wdata_i;
    end
  end

  for (genvar g = 0; g < DW; g++) begin : g_pin
    assign drv[g] = dir_q[g] & data_q[g];
  end

  assign pin_o  = {par_fill(^drv, par_odd_i), drv};
  assign data_o = data_q;
  assign dir_o  = dir_q;
endmodule

// File: rtl/gpio_par_insamp.sv
`timescale 1ns/1ps
module gpio_par_insamp #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW:0]   pin_i,
  input  logic          par_odd_i,
  input  logic          fault_i,
  output logic [DW-1:0] in_o,
  output logic          err_o
);
  logic [DW-1:0] in_q;
  logic          err_q, bad;

  assign bad = (^pin_i) != par_odd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      err_q <= 1'b0;
    end else begin
      in_q  <= pin_i[DW-1:0];
      err_q <= bad | fault_i;
    end
  end

  assign in_o  = in_q;
  assign err_o = err_q;
endmodule

// File: rtl/gpio_par_top.sv
`timescale 1ns/1ps
module gpio_par_top
  import gpio_par_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned BW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [BW-1:0] haddr_i,
  input  logic [1:0]    htrans_i,
  input  logic          hwrite_i,
  input  logic          hsel_i,
  input  logic          hready_i,
  input  logic [BW-1:0] hwdata_i,
  input  logic [DW:0]   pin_in_i,
  input  logic          par_odd_i,
  input  logic          fault_inj_i,
  output logic          hreadyout_o,
  output logic [BW-1:0] hrdata_o,
  output logic [DW:0]   pin_out_o,
  output logic          par_err_o
);
  logic          wr_data, wr_dir, rd_data, rd_dir;
  logic [DW-1:0] data_w, dir_w, in_w;
  logic          unused_bus;

  assign unused_bus = ^{haddr_i[BW-1:DEC_W], hwdata_i[BW-1:DW]};

  gpio_par_front u_front (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hsel_i    (hsel_i),
    .hready_i  (hready_i),
    .htrans_i  (htrans_i),
    .hwrite_i  (hwrite_i),
    .haddr_i   (haddr_i[DEC_W-1:0]),
    .wr_data_o (wr_data),
    .wr_dir_o  (wr_dir),
    .rd_data_o (rd_data),
    .rd_dir_o  (rd_dir)
  );

  gpio_par_outregs #(.DW(DW)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_data_i (wr_data),
    .wr_dir_i  (wr_dir),
    .wdata_i   (hwdata_i[DW-1:0]),
    .par_odd_i (par_odd_i),
    .data_o    (data_w),
    .dir_o     (dir_w),
    .pin_o     (pin_out_o)
  );

  gpio_par_insamp #(.DW(DW)) u_in (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_i     (pin_in_i),
    .par_odd_i (par_odd_i),
    .fault_i   (fault_inj_i),
    .in_o      (in_w),
    .err_o     (par_err_o)
  );

  always_comb begin
    hrdata_o = '0;
    if (rd_data)     hrdata_o[DW-1:0] = (in_w & ~dir_w) | (data_w & dir_w);
    else if (rd_dir) hrdata_o[DW-1:0] = dir_w;
  end

  assign hreadyout_o = 1'b1;
endmodule

// File: rtl/gpio_par_chk.sv
`timescale 1ns/1ps
module gpio_par_chk
  import gpio_par_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned BW = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hsel_i,
  input logic             hready_i,
  input logic             htrans1_i,
  input logic             hwrite_i,
  input logic [DEC_W-1:0] ofs_i,
  input logic [DW-1:0]    wdata_i,
  input logic [DW:0]      pin_in_i,
  input logic             par_odd_i,
  input logic             fault_inj_i,
  input logic             hreadyout_o,
  input logic [BW-1:0]    hrdata_o,
  input logic [DW:0]      pin_out_o,
  input logic             par_err_o,
  input logic [DW-1:0]    dir_i
);
  logic [1:0] age;
  logic       wr_ap, rd_ap;

  assign wr_ap = hsel_i & hready_i & htrans1_i &  hwrite_i;
  assign rd_ap = hsel_i & hready_i & htrans1_i & ~hwrite_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_READY_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hreadyout_o); // R9

  AST_DIR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2 && $past(wr_ap && ofs_i == OFS_DIR, 2)) |-> (dir_i == $past(wdata_i))); // R3

  AST_DATA_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2 && $past(wr_ap && ofs_i == OFS_DATA, 2) && ($past(dir_i) == '1))
      |-> (pin_out_o[DW-1:0] == $past(wdata_i))); // R2

  AST_READ_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd1 && $past(rd_ap && ofs_i == OFS_DATA) && (dir_i == '0))
      |-> (hrdata_o == BW'($past(pin_in_i[DW-1:0])))); // R6

  AST_RDATA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd1 && !$past(rd_ap && (ofs_i == OFS_DATA || ofs_i == OFS_DIR)))
      |-> (hrdata_o == '0)); // R8

  AST_OUT_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_out_o[DW-1:0] & ~dir_i) == '0)); // R4

  AST_OUT_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((^pin_out_o) == par_odd_i)); // R5

  AST_ERR_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((^pin_in_i) != par_odd_i) |=> par_err_o); // R10

  AST_ERR_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((^pin_in_i) == par_odd_i) && !fault_inj_i) |=> !par_err_o); // R10

  AST_FAULT_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_inj_i |=> par_err_o); // R11
endmodule

bind gpio_par_top gpio_par_chk #(.DW(DW), .BW(BW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hsel_i      (hsel_i),
  .hready_i    (hready_i),
  .htrans1_i   (htrans_i[1]),
  .hwrite_i    (hwrite_i),
  .ofs_i       (haddr_i[7:0]),
  .wdata_i     (hwdata_i[DW-1:0]),
  .pin_in_i    (pin_in_i),
  .par_odd_i   (par_odd_i),
  .fault_inj_i (fault_inj_i),
  .hreadyout_o (hreadyout_o),
  .hrdata_o    (hrdata_o),
  .pin_out_o   (pin_out_o),
  .par_err_o   (par_err_o),
  .dir_i       (dir_w)
);

// File: tb/tb_gpio_par_top.sv
`timescale 1ns/1ps
module tb_gpio_par_top;
  localparam int DW = 16;
  localparam int BW = 32;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [BW-1:0] haddr, hwdata;
  logic [1:0]    htrans;
  logic          hwrite, hsel, hready;
  logic [DW:0]   pin_in;
  logic          par_odd, fault;
  logic          hreadyout, par_err;
  logic [BW-1:0] hrdata;
  logic [DW:0]   pin_out;

  always #2.5 clk = ~clk;

  gpio_par_top #(.DW(DW), .BW(BW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .haddr_i(haddr), .htrans_i(htrans),
    .hwrite_i(hwrite), .hsel_i(hsel), .hready_i(hready), .hwdata_i(hwdata),
    .pin_in_i(pin_in), .par_odd_i(par_odd), .fault_inj_i(fault),
    .hreadyout_o(hreadyout), .hrdata_o(hrdata), .pin_out_o(pin_out),
    .par_err_o(par_err)
  );

  int    n_vec = 0, n_bad = 0;
  bit    done = 0;
  string tag = "";

  // reference model state
  logic [DW-1:0] m_data, m_dir, m_in;
  logic          m_err, m_vld, m_wr;
  logic [7:0]    m_ofs;

  function automatic logic [DW:0] good_word(input logic [DW-1:0] d, input logic odd);
    logic p;
    p = (($countones(d) % 2) == 0) ? odd : !odd;
    return {p, d};
  endfunction

  task automatic model_edge();
    if (!rst_ni) begin
      m_data = '0; m_dir = '0; m_in = '0; m_err = 0; m_vld = 0; m_wr = 0; m_ofs = '0;
    end else begin
      if (m_vld && m_wr) begin
        if (m_ofs == 8'h00)      m_data = hwdata[DW-1:0];
        else if (m_ofs == 8'h04) m_dir  = hwdata[DW-1:0];
      end
      m_in  = pin_in[DW-1:0];
      m_err = fault || (($countones(pin_in) % 2) != (par_odd ? 1 : 0));
      m_vld = hsel && hready && htrans[1];
      m_wr  = hwrite;
      m_ofs = haddr[7:0];
    end
  endtask

  task automatic chk(input string what, input logic [BW-1:0] got, input logic [BW-1:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic compare();
    logic [DW-1:0] e_pin;
    logic          e_par;
    logic [BW-1:0] e_rd;
    e_pin = m_data & m_dir;
    e_par = (($countones(e_pin) % 2) == 0) ? par_odd : !par_odd;
    e_rd  = '0;
    if (m_vld && !m_wr) begin
      if (m_ofs == 8'h00)      e_rd[DW-1:0] = (m_in & ~m_dir) | (m_data & m_dir);
      else if (m_ofs == 8'h04) e_rd[DW-1:0] = m_dir;
    end
    chk("R2 R4 pin_out[15:0]", BW'(pin_out[DW-1:0]), BW'(e_pin));
    chk("R5 pin_out[16]", BW'(pin_out[DW]), BW'(e_par));
    chk("R6 R7 R8 hrdata", hrdata, e_rd);
    chk("R10 R11 par_err", BW'(par_err), BW'(m_err));
    if (rst_ni) chk("R9 hreadyout", BW'(hreadyout), BW'(1));
  endtask

  task automatic step(input logic s, input logic r, input logic [1:0] t, input logic w,
                      input logic [BW-1:0] a, input logic [BW-1:0] wd,
                      input logic [DW:0] pin, input logic odd, input logic flt);
    @(posedge clk);
    #1;
    model_edge();
    hsel = s; hready = r; htrans = t; hwrite = w; haddr = a; hwdata = wd;
    pin_in = pin; par_odd = odd; fault = flt;
    #1;
    compare();
  endtask

  task automatic idle(input logic [BW-1:0] wd, input logic [DW:0] pin, input logic odd);
    step(0, 1, 2'b00, 0, '0, wd, pin, odd, 0);
  endtask

  initial begin
    rst_ni = 0; hsel = 0; hready = 1; htrans = 0; hwrite = 0; haddr = '0; hwdata = '0;
    pin_in = '0; par_odd = 1; fault = 0;
    #1;
    tag = "R12 reset";
    compare();
    idle('0, '0, 1);
    idle('0, 17'h1_0000, 0);
    rst_ni = 1;
    idle('0, good_word(16'h0, 1), 1);

    tag = "R3 direction write";
    step(1, 1, 2'b10, 1, 32'h4, '0, good_word(16'h0, 1), 1, 0);
    idle(32'hFFFF, good_word(16'h0, 1), 1);
    idle('0, good_word(16'h0, 1), 1);

    tag = "R2 data write all outputs";
    step(1, 1, 2'b10, 1, 32'h0, '0, good_word(16'h0, 1), 1, 0);
    idle(32'hDEAD_A5C3, good_word(16'h0, 1), 1);
    idle('0, good_word(16'h0, 1), 0);

    tag = "R4 partial direction";
    step(1, 1, 2'b11, 1, 32'h104, '0, good_word(16'h0, 0), 0, 0);
    idle(32'h00FF, good_word(16'h0, 0), 0);
    step(1, 1, 2'b10, 1, 32'h0, '0, good_word(16'h0, 0), 0, 0);
    idle(32'h1234, good_word(16'h0, 0), 0);

    tag = "R6 read mixed pins";
    step(1, 1, 2'b10, 0, 32'h0, '0, good_word(16'hBEEF, 1), 1, 0);
    step(1, 1, 2'b10, 0, 32'h0, '0, good_word(16'h0F0F, 1), 1, 0);
    idle('0, good_word(16'h5555, 1), 1);

    tag = "R7 read direction";
    step(1, 1, 2'b10, 0, 32'h4, '0, good_word(16'h0, 1), 1, 0);
    idle('0, good_word(16'h0, 1), 1);

    tag = "R6 back to back write then read";
    step(1, 1, 2'b10, 1, 32'h0, '0, good_word(16'hAAAA, 1), 1, 0);
    step(1, 1, 2'b10, 0, 32'h0, 32'h0000_C3C3, good_word(16'hAAAA, 1), 0, 0);
    idle('0, good_word(16'h0, 0), 0);

    tag = "R1 invalid transfers";
    step(0, 1, 2'b10, 1, 32'h0, '0, good_word(16'h0, 0), 0, 0);
    step(1, 0, 2'b10, 1, 32'h0, 32'h0000_1111, good_word(16'h0, 0), 0, 0);
    step(1, 1, 2'b01, 1, 32'h4, 32'h0000_2222, good_word(16'h0, 0), 0, 0);
    step(1, 1, 2'b00, 0, 32'h0, 32'h0000_3333, good_word(16'h0, 0), 0, 0);
    step(1, 1, 2'b10, 0, 32'h4, '0, good_word(16'h0, 0), 0, 0);
    idle('0, good_word(16'h0, 0), 0);

    tag = "R8 unmapped offset";
    step(1, 1, 2'b10, 1, 32'h8, '0, good_word(16'h0, 0), 0, 0);
    step(1, 1, 2'b10, 0, 32'h8, 32'h0000_FFFF, good_word(16'h0, 0), 0, 0);
    step(1, 1, 2'b10, 0, 32'hC, '0, good_word(16'h0, 0), 0, 0);
    step(1, 1, 2'b10, 0, 32'h0, '0, good_word(16'h0, 0), 0, 0);
    idle('0, good_word(16'h0, 0), 0);

    tag = "R10 parity error";
    idle('0, good_word(16'h1234, 1) ^ 17'h1_0000, 1);
    idle('0, good_word(16'h1234, 0) ^ 17'h1_0000, 0);
    idle('0, good_word(16'h7777, 0), 1);
    idle('0, good_word(16'h7777, 0), 0);
    idle('0, good_word(16'h7777, 0), 0);

    tag = "R11 fault inject";
    step(0, 1, 2'b00, 0, '0, '0, good_word(16'h8001, 0), 0, 1);
    idle('0, good_word(16'h8001, 0), 0);
    idle('0, good_word(16'h8001, 0), 0);

    tag = "R5 R10 random traffic";
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] rv;
      logic [BW-1:0] a;
      rv = $urandom;
      case (rv[3:2])
        2'd0: a = 32'h0;
        2'd1: a = 32'h4;
        2'd2: a = 32'h8;
        default: a = 32'h100;
      endcase
      step(rv[4] | rv[5], rv[6] | rv[7], rv[9:8], rv[10], a, $urandom,
           17'($urandom), rv[11], (rv[15:12] == 4'h0));
    end

    tag = "R12 reset mid run";
    rst_ni = 0;
    #1;
    model_edge();
    compare();
    idle('0, '0, 1);
    rst_ni = 1;
    idle('0, good_word(16'h0, 0), 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL R9 watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule